// File: doc/BRIEF.md
# Bus Clock Ratio Divider

This block turns one source clock into four clock-enable streams: a processor stream, a double-rate bus stream, a bus stream and a peripheral stream. The processor stream divides the source directly. The double-rate bus stream divides the source through a pre-divider and a second divider. The bus and peripheral streams each divide the double-rate stream again. Each stream fans out into a small vector of lanes, and every lane has a mask bit, so software can switch off the clock of any consumer it does not need.

Ratio and mode writes are not applied at once. They wait in a pending copy until every counter in the chain reaches its terminal count in the same cycle. All counters then restart together under the new setting, so no stream ever sees a shortened or stretched period. A synchronous mode replaces the processor, pre-divider, double-rate and bus divisors with a fixed 2 : 5 : 10 set, measured in source cycles. Mask changes are applied at each stream's own pulse, so every pulse a stream emits is either passed whole or masked whole.

Top module: `busclk_ratio_div`

## Requirements
- R1: While reset is held and in the cycles after it, all ratio fields are 0, synchronous mode is off and every mask bit is 1, so every lane of all four streams pulses in every source cycle.
- R2: Outside synchronous mode the processor stream pulses once every A+1 source cycles, where A is the ratio word bits [3:0] (1 to 16).
- R3: Outside synchronous mode the double-rate stream pulses once every (M+1)*(X+1) source cycles, with the pre-divider M in bits [7:4] and X in bits [11:9].
- R4: The bus stream pulses once every (H+1) double-rate periods, with H in bit 8, and it pulses only in cycles where the double-rate stream also pulses.
- R5: The peripheral stream pulses once every (P+1) double-rate periods, with P in bits [15:12], and it pulses only in cycles where the double-rate stream also pulses.
- R6: Mask words live at address 4 (processor), 5 (double-rate), 6 (bus) and 7 (peripheral). Bit i set to 1 passes lane i and 0 blocks it. A written mask is copied into use at that stream's next pulse and governs the pulses after that one. A lane is never active outside its stream's pulse.
- R7: The ratio word (address 0) and the mode word (address 1, bit 0) are held pending. They take effect only in the cycle after the processor, bus and peripheral streams all pulse together. At that point all counters restart from zero.
- R8: With synchronous mode in effect, the processor, double-rate and bus streams have periods of 2, 5 and 10 source cycles whatever bits [11:0] hold, and the peripheral stream has a period of 5*(P+1).
- R9: Writes to addresses 2 and 3 change no stream and no mask.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Source clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | 16 | Register write data |
| cpu_ce | output | GATE_W | Processor-stream lane enables |
| x2_ce | output | GATE_W | Double-rate bus-stream lane enables |
| bus_ce | output | GATE_W | Bus-stream lane enables |
| per_ce | output | GATE_W | Peripheral-stream lane enables |

## Verification
A register write can land on the same edge as a common terminal count. A mask write can also land on the same edge as that stream's pulse. In both cases the design must apply the old pending value and keep the new value for the next boundary. The bench provokes these collisions by spacing its writes with random idle gaps, under random ratio sets whose common terminal recurs every few cycles. It judges each cycle against a model that derives every pulse from the cycle count since the last restart, modulo each stream's period.

// File: rtl/bcr_pkg.sv
package bcr_pkg;
  localparam int ADDR_W = 3;
  localparam int DATA_W = 16;
  localparam int NDOM   = 4;
  localparam int ARM_W  = 4;
  localparam int PRE_W  = 4;
  localparam int X2_W   = 3;
  localparam int BUS_W  = 1;
  localparam int PER_W  = 4;
  localparam int CNT_W  = 5;

  localparam int D_CPU = 0;
  localparam int D_X2  = 1;
  localparam int D_BUS = 2;
  localparam int D_PER = 3;

  localparam logic [ADDR_W-1:0] A_RATIO = 3'd0;
  localparam logic [ADDR_W-1:0] A_MODE  = 3'd1;

  localparam int SYNC_CPU = 2;
  localparam int SYNC_PRE = 1;
  localparam int SYNC_X2  = 5;
  localparam int SYNC_BUS = 2;

  // Field positions follow the packed order, MSB first.
  typedef struct packed {
    logic [PER_W-1:0] per;
    logic [X2_W-1:0]  x2;
    logic [BUS_W-1:0] bus;
    logic [PRE_W-1:0] pre;
    logic [ARM_W-1:0] arm;
  } ratio_t;

  typedef struct packed {
    logic   sync;
    ratio_t r;
  } cfg_t;

  typedef struct packed {
    logic [CNT_W-1:0] cpu;
    logic [CNT_W-1:0] pre;
    logic [CNT_W-1:0] x2;
    logic [CNT_W-1:0] bus;
    logic [CNT_W-1:0] per;
  } div_t;

  // Divisor set actually used by the counter chain.
  function automatic div_t eff_div(input cfg_t c);
    div_t d;
    d.per = CNT_W'(c.r.per) + CNT_W'(1);
    if (c.sync) begin
      d.cpu = CNT_W'(SYNC_CPU);
      d.pre = CNT_W'(SYNC_PRE);
      d.x2  = CNT_W'(SYNC_X2);
      d.bus = CNT_W'(SYNC_BUS);
    end else begin
      d.cpu = CNT_W'(c.r.arm) + CNT_W'(1);
      d.pre = CNT_W'(c.r.pre) + CNT_W'(1);
      d.x2  = CNT_W'(c.r.x2)  + CNT_W'(1);
      d.bus = CNT_W'(c.r.bus) + CNT_W'(1);
    end
    return d;
  endfunction

  function automatic logic at_term(input logic [CNT_W-1:0] cnt,
                                   input logic [CNT_W-1:0] div);
    return cnt == (div - CNT_W'(1));
  endfunction
endpackage

// File: rtl/bcr_regs.sv
module bcr_regs
  import bcr_pkg::*;
#(
  parameter int GATE_W = 4
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wr_en,
  input  logic [ADDR_W-1:0]             wr_addr,
  input  logic [DATA_W-1:0]             wr_data,
  input  logic                          common_term,
  output cfg_t                          cfg_act,
  output logic [NDOM-1:0][GATE_W-1:0]   gate_pend
);
  cfg_t cfg_pend;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_pend <= '0;
    end else if (wr_en && wr_addr == A_RATIO) begin
      cfg_pend.r <= ratio_t'(wr_data);
    end else if (wr_en && wr_addr == A_MODE) begin
      cfg_pend.sync <= wr_data[0];
    end
  end

  // Deferred commit: only at the shared terminal count.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cfg_act <= '0;
    else if (common_term) cfg_act <= cfg_pend;
  end

  for (genvar d = 0; d < NDOM; d++) begin : g_mask
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        gate_pend[d] <= '1;
      else if (wr_en && wr_addr[ADDR_W-1] && wr_addr[1:0] == 2'(d))
        gate_pend[d] <= wr_data[GATE_W-1:0];
    end
  end
endmodule

// File: rtl/bcr_chain.sv
module bcr_chain
  import bcr_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  cfg_t            cfg_act,
  output logic [NDOM-1:0] tick,
  output logic            common_term
);
  div_t dv;
  logic [CNT_W-1:0] cpu_c, pre_c, x2_c, bus_c, per_c;
  logic pre_tick;

  assign dv       = eff_div(cfg_act);
  assign pre_tick = at_term(pre_c, dv.pre);

  assign tick[D_CPU] = at_term(cpu_c, dv.cpu);
  assign tick[D_X2]  = pre_tick && at_term(x2_c, dv.x2);
  assign tick[D_BUS] = tick[D_X2] && at_term(bus_c, dv.bus);
  assign tick[D_PER] = tick[D_X2] && at_term(per_c, dv.per);

  assign common_term = tick[D_CPU] && tick[D_BUS] && tick[D_PER];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cpu_c <= '0;
      pre_c <= '0;
      x2_c  <= '0;
      bus_c <= '0;
      per_c <= '0;
    end else begin
      cpu_c <= tick[D_CPU] ? '0 : cpu_c + CNT_W'(1);
      pre_c <= pre_tick ? '0 : pre_c + CNT_W'(1);
      if (pre_tick)   x2_c  <= tick[D_X2]  ? '0 : x2_c  + CNT_W'(1);
      if (tick[D_X2]) bus_c <= tick[D_BUS] ? '0 : bus_c + CNT_W'(1);
      if (tick[D_X2]) per_c <= tick[D_PER] ? '0 : per_c + CNT_W'(1);
    end
  end
endmodule

// File: rtl/bcr_gate.sv
module bcr_gate #(
  parameter int GATE_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic [GATE_W-1:0] pend,
  output logic [GATE_W-1:0] act,
  output logic [GATE_W-1:0] ce
);
  // Mask is swapped only on a pulse so each pulse is whole.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    act <= '1;
    else if (tick) act <= pend;
  end

  assign ce = tick ? act : '0;
endmodule

// File: rtl/busclk_ratio_div.sv
module busclk_ratio_div
  import bcr_pkg::*;
#(
  parameter int GATE_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [2:0]        wr_addr,
  input  logic [15:0]       wr_data,
  output logic [GATE_W-1:0] cpu_ce,
  output logic [GATE_W-1:0] x2_ce,
  output logic [GATE_W-1:0] bus_ce,
  output logic [GATE_W-1:0] per_ce
);
  cfg_t                        cfg_act;
  logic [NDOM-1:0]             tick;
  logic                        common_term;
  logic [NDOM-1:0][GATE_W-1:0] gate_pend;
  logic [NDOM-1:0][GATE_W-1:0] gate_act;
  logic [NDOM-1:0][GATE_W-1:0] ce_all;

  bcr_regs #(.GATE_W(GATE_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .common_term(common_term), .cfg_act(cfg_act),
    .gate_pend(gate_pend)
  );

  bcr_chain u_chain (
    .clk(clk), .rst_n(rst_n), .cfg_act(cfg_act), .tick(tick),
    .common_term(common_term)
  );

  for (genvar d = 0; d < NDOM; d++) begin : g_dom
    bcr_gate #(.GATE_W(GATE_W)) u_gate (
      .clk(clk), .rst_n(rst_n), .tick(tick[d]), .pend(gate_pend[d]),
      .act(gate_act[d]), .ce(ce_all[d])
    );
  end

  assign cpu_ce = ce_all[D_CPU];
  assign x2_ce  = ce_all[D_X2];
  assign bus_ce = ce_all[D_BUS];
  assign per_ce = ce_all[D_PER];
endmodule

// File: rtl/busclk_ratio_div_chk.sv
module busclk_ratio_div_chk
  import bcr_pkg::*;
#(
  parameter int GATE_W = 4
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic [NDOM-1:0]             tick,
  input logic                        common_term,
  input cfg_t                        cfg_act,
  input logic [NDOM-1:0][GATE_W-1:0] gate_act,
  input logic [NDOM-1:0][GATE_W-1:0] ce_all
);
  // R4
  bus_in_x2_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick[D_BUS] |-> tick[D_X2]);

  // R5
  per_in_x2_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick[D_PER] |-> tick[D_X2]);

  // R7
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !common_term |=> $stable(cfg_act));

  // R8
  sync_cpu_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_act.sync && tick[D_CPU]) |=> (!tick[D_CPU] || !cfg_act.sync));

  for (genvar d = 0; d < NDOM; d++) begin : g_chk
    // R6
    mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !tick[d] |=> $stable(gate_act[d]));
    // R6
    lane_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|ce_all[d]) |-> tick[d]);
  end
endmodule

bind busclk_ratio_div busclk_ratio_div_chk #(.GATE_W(GATE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .common_term(common_term),
  .cfg_act(cfg_act), .gate_act(gate_act), .ce_all(ce_all)
);

// File: tb/tb_busclk_ratio_div.sv
module tb_busclk_ratio_div;
  localparam int CLK_PERIOD = 10;
  localparam int G = 4;
  localparam int WATCHDOG = 150000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [G-1:0] cpu_ce, x2_ce, bus_ce, per_ce;

  int checks = 0;
  int fails = 0;
  string ovr = "";

  // reference model state
  logic [15:0] act_r, pend_r;
  bit act_s, pend_s;
  int t;
  logic [G-1:0] g_act [4];
  logic [G-1:0] g_pend [4];

  always #(CLK_PERIOD/2) clk = ~clk;

  busclk_ratio_div #(.GATE_W(G)) dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .cpu_ce(cpu_ce), .x2_ce(x2_ce), .bus_ce(bus_ce),
    .per_ce(per_ce)
  );

  // Period of stream d in source cycles, per R2, R3, R4, R5, R8.
  function automatic int plen(input int d, input logic [15:0] r, input bit s);
    int dbl;
    dbl = s ? 5 : (int'(r[7:4]) + 1) * (int'(r[11:9]) + 1);
    case (d)
      0: return s ? 2 : int'(r[3:0]) + 1;
      1: return dbl;
      2: return s ? 10 : dbl * (int'(r[8]) + 1);
      default: return dbl * (int'(r[15:12]) + 1);
    endcase
  endfunction

  function automatic logic [G-1:0] got(input int d);
    case (d)
      0: return cpu_ce;
      1: return x2_ce;
      2: return bus_ce;
      default: return per_ce;
    endcase
  endfunction

  function automatic string tag_of(input int d);
    if (ovr != "") return ovr;
    if (pend_r != act_r || pend_s != act_s) return "R7";
    if (g_act[d] != '1) return "R6";
    if (act_s) return "R8";
    case (d)
      0: return "R2";
      1: return "R3";
      2: return "R4";
      default: return "R5";
    endcase
  endfunction

  task automatic compare();
    for (int d = 0; d < 4; d++) begin
      logic [G-1:0] exp;
      exp = (((t + 1) % plen(d, act_r, act_s)) == 0) ? g_act[d] : '0;
      checks++;
      if (got(d) !== exp) begin
        fails++;
        $display("FAIL %s stream %0d t=%0d: got %b expected %b",
                 tag_of(d), d, t, got(d), exp);
      end
    end
  endtask

  task automatic model_step(input logic we, input logic [2:0] a,
                            input logic [15:0] dat);
    logic [3:0] tk;
    bit cm;
    for (int i = 0; i < 4; i++) tk[i] = ((t + 1) % plen(i, act_r, act_s)) == 0;
    cm = tk[0] && tk[2] && tk[3];
    for (int i = 0; i < 4; i++) if (tk[i]) g_act[i] = g_pend[i];
    if (cm) begin
      act_r = pend_r;
      act_s = pend_s;
      t = 0;
    end else begin
      t = t + 1;
    end
    if (we) begin
      if (a == 3'd0) pend_r = dat;
      else if (a == 3'd1) pend_s = dat[0];
      else if (a[2]) g_pend[a[1:0]] = dat[G-1:0];
    end
  endtask

  task automatic cyc(input logic we, input logic [2:0] a, input logic [15:0] dat);
    @(negedge clk);
    compare();
    wr_en = we;
    wr_addr = a;
    wr_data = dat;
    model_step(we, a, dat);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(1'b0, 3'd0, 16'h0);
  endtask

  task automatic wait_commit();
    for (int i = 0; i < 6000; i++) begin
      if (pend_r == act_r && pend_s == act_s) break;
      cyc(1'b0, 3'd0, 16'h0);
    end
  endtask

  initial begin : watchdog
    repeat (WATCHDOG) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired: got running expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin : main
    void'($urandom(32'h1A2B3C));
    repeat (4) @(negedge clk);
    // R1: in reset every lane of every stream is active
    for (int d = 0; d < 4; d++) begin
      checks++;
      if (got(d) !== '1) begin
        fails++;
        $display("FAIL R1 reset stream %0d: got %b expected %b", d, got(d), {G{1'b1}});
      end
    end
    rst_n = 1'b1;
    act_r = '0; pend_r = '0; act_s = 0; pend_s = 0; t = 0;
    for (int i = 0; i < 4; i++) begin g_act[i] = '1; g_pend[i] = '1; end
    model_step(1'b0, 3'd0, 16'h0);
    ovr = "R1";
    idle(8);
    ovr = "";

    // R6: lane masks
    cyc(1'b1, 3'd4, 16'h0005);
    cyc(1'b1, 3'd7, 16'h0000);
    cyc(1'b1, 3'd6, 16'h000A);
    idle(12);
    cyc(1'b1, 3'd0, 16'h3000);   // peripheral period 4
    wait_commit();
    idle(10);
    cyc(1'b1, 3'd7, 16'h0009);
    idle(12);

    // R7: ratio change waits for the shared terminal count
    cyc(1'b1, 3'd0, 16'h3001);
    wait_commit();
    idle(20);
    cyc(1'b1, 3'd0, 16'h1213);
    wait_commit();
    idle(40);

    // R8: synchronous mode with fields 0,0,1 then with other fields
    cyc(1'b1, 3'd0, 16'h3100);
    cyc(1'b1, 3'd1, 16'h0001);
    wait_commit();
    idle(60);
    cyc(1'b1, 3'd0, 16'h2FF7);
    wait_commit();
    idle(60);
    cyc(1'b1, 3'd1, 16'h0000);
    cyc(1'b1, 3'd0, 16'h0000);
    wait_commit();
    idle(10);

    // R9: unused addresses
    ovr = "R9";
    cyc(1'b1, 3'd2, 16'hFFFF);
    cyc(1'b1, 3'd3, 16'hFFFF);
    idle(20);
    ovr = "";

    // Random ratio sets, masks and write spacing
    for (int it = 0; it < 14; it++) begin
      logic [15:0] r;
      r = {4'($urandom % 8), 3'($urandom % 8), 1'($urandom % 2),
           4'($urandom % 2), 4'($urandom % 16)};
      for (int k = 0; k < 4; k++) begin
        cyc(1'b1, 3'(4 + k), 16'($urandom));
        idle($urandom % 4);
      end
      cyc(1'b1, 3'd0, r);
      idle($urandom % 4);
      cyc(1'b1, 3'd1, {15'h0, 1'(it % 5 == 3)});
      wait_commit();
      idle(150);
    end

    @(negedge clk);
    compare();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule